// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Decoder

This block turns a 16-bit CPU address and a memory-request strobe into the chip selects for a small memory system. The system holds one 16K-word ROM region and five RAM groups. Each RAM group is two 8K×8 chips placed side by side: one chip carries D15..D8 and the other carries D7..D0, so together they form a 16-bit data path. The block is purely combinational. The top three address bits pick an 8K bank, and the low thirteen bits are passed unchanged to every chip as the on-chip address.

Bank 0 and bank 1 are merged into a single ROM select. Banks 3 to 7 select RAM groups 0 to 4 in order. Bank 2 (4000H–5FFFH) is a hole: no chip answers there, so a read leaves the data bus undriven. Every select and the RAM write enable are active low. When the memory request is inactive, all of them stay high. A write aimed at the ROM or at the hole never pulls the RAM write enable low.

Top module: `cs_decoder`

## Requirements
- R1: While `mreq_n` is high, `rom_cs_n`, every bit of `ram_cs_n` and `ram_we_n` are all high, for every address and for both values of `rd_wr_n`.
- R2: While `mreq_n` is low and `cpu_addr[15:13]` is 000 or 001 (0000H–3FFFH), `rom_cs_n` is low and all of `ram_cs_n` are high.
- R3: While `mreq_n` is low and `cpu_addr[15:13]` is 010 (4000H–5FFFH), every select is high and `ram_we_n` is high.
- R4: While `mreq_n` is low and `cpu_addr[15:13]` is 011, 100, 101, 110 or 111, exactly `ram_cs_n[0]`, `[1]`, `[2]`, `[3]` or `[4]` respectively is low, and `rom_cs_n` is high.
- R5: At no time is more than one of the six selects low.
- R6: `chip_addr` always equals `cpu_addr[12:0]`, whatever the values of `mreq_n` and `rd_wr_n`.
- R7: `ram_we_n` is low exactly when `mreq_n` is low, `rd_wr_n` is low (write), and one RAM group is selected. A write to the ROM region leaves `ram_we_n` high.
- R8: While `rd_wr_n` is high (read), `ram_we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU word address |
| mreq_n | input | 1 | Memory request, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| rom_cs_n | output | 1 | ROM region select, active low |
| ram_cs_n | output | 5 | RAM group selects, active low, bit k = group k |
| chip_addr | output | 13 | On-chip address driven to every chip |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The main function is tried on all eight bank codes, each with the strobe active and inactive and with both transfer directions. This separates a wrong bank-to-group mapping, a ROM merge that covers too many or too few banks, and a select that leaks into the hole. Random addresses vary the low thirteen bits, which shows whether the on-chip address is passed through intact or whether low bits affect the selects. Write cycles to the ROM, to the hole and with the strobe idle show whether the write enable is gated correctly.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;
   // Address geometry shared by the decoder and its checker
   localparam int unsigned CPU_AW      = 16;
   localparam int unsigned CHIP_AW     = 13;
   localparam int unsigned BANK_W      = CPU_AW - CHIP_AW;
   localparam int unsigned NUM_BANKS   = 1 << BANK_W;
   // Memory map in units of banks
   localparam int unsigned ROM_FIRST   = 0;
   localparam int unsigned ROM_BANKS   = 2;
   localparam int unsigned RAM_FIRST   = 3;
   localparam int unsigned RAM_GROUPS  = 5;

   typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned OUT_N = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             en_n,
   output logic [OUT_N-1:0] out_n
);
   // One active-low line per code, all high when disabled
   for (genvar k = 0; k < OUT_N; k++) begin : g_line
      assign out_n[k] = en_n | (sel != SEL_W'(k));
   end
endmodule

// File: rtl/cs_region_merge.sv
module cs_region_merge #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned FIRST     = 0,
   parameter int unsigned COUNT     = 2
) (
   input  logic [NUM_LINES-1:0] lines_n,
   output logic                 merged_n
);
   if (FIRST + COUNT > NUM_LINES || COUNT == 0) begin : g_bad_range
      $error("cs_region_merge: line range out of bounds");
   end

   logic [COUNT-1:0] picked_n;
   for (genvar i = 0; i < COUNT; i++) begin : g_pick
      assign picked_n[i] = lines_n[FIRST+i];
   end

   // Active-low OR of selects is an AND of the lines
   if (COUNT == 1) begin : g_single
      assign merged_n = picked_n[0];
   end else begin : g_multi
      assign merged_n = &picked_n;
   end
endmodule

// File: rtl/cs_write_gate.sv
module cs_write_gate #(
   parameter int unsigned GROUPS = 5
) (
   input  logic              mreq_n,
   input  logic              rd_wr_n,
   input  logic [GROUPS-1:0] group_cs_n,
   output logic              we_n
);
   logic any_group;
   assign any_group = ~(&group_cs_n);
   assign we_n      = ~(~mreq_n & ~rd_wr_n & any_group);
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
   import cs_decoder_pkg::*;
#(
   parameter int unsigned ADDR_W    = CPU_AW,
   parameter int unsigned ONCHIP_W  = CHIP_AW,
   parameter int unsigned ROM_START = ROM_FIRST,
   parameter int unsigned ROM_SPAN  = ROM_BANKS,
   parameter int unsigned RAM_START = RAM_FIRST,
   parameter int unsigned RAM_COUNT = RAM_GROUPS,
   localparam int unsigned SEL_W    = ADDR_W - ONCHIP_W,
   localparam int unsigned BANKS    = 1 << SEL_W
) (
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 mreq_n,
   input  logic                 rd_wr_n,
   output logic                 rom_cs_n,
   output logic [RAM_COUNT-1:0] ram_cs_n,
   output logic [ONCHIP_W-1:0]  chip_addr,
   output logic                 ram_we_n
);
   if (ONCHIP_W >= ADDR_W) begin : g_bad_width
      $error("cs_decoder: on-chip address must be narrower than CPU address");
   end
   if (RAM_START + RAM_COUNT > BANKS) begin : g_bad_ram
      $error("cs_decoder: RAM groups exceed bank count");
   end
   if (ROM_START + ROM_SPAN > RAM_START) begin : g_bad_overlap
      $error("cs_decoder: ROM and RAM banks overlap");
   end

   logic [SEL_W-1:0] bank_sel;
   logic [BANKS-1:0] bank_n;

   assign bank_sel  = cpu_addr[ADDR_W-1:ONCHIP_W];
   assign chip_addr = cpu_addr[ONCHIP_W-1:0];

   cs_bank_decoder #(.SEL_W(SEL_W)) dec_i (
      .sel   (bank_sel),
      .en_n  (mreq_n),
      .out_n (bank_n)
   );

   cs_region_merge #(
      .NUM_LINES (BANKS),
      .FIRST     (ROM_START),
      .COUNT     (ROM_SPAN)
   ) rom_i (
      .lines_n  (bank_n),
      .merged_n (rom_cs_n)
   );

   for (genvar g = 0; g < RAM_COUNT; g++) begin : g_ram
      assign ram_cs_n[g] = bank_n[RAM_START+g];
   end

   cs_write_gate #(.GROUPS(RAM_COUNT)) we_i (
      .mreq_n     (mreq_n),
      .rd_wr_n    (rd_wr_n),
      .group_cs_n (ram_cs_n),
      .we_n       (ram_we_n)
   );
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned ONCHIP_W  = 13,
   parameter int unsigned RAM_COUNT = 5
) (
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic                 mreq_n,
   input logic                 rd_wr_n,
   input logic                 rom_cs_n,
   input logic [RAM_COUNT-1:0] ram_cs_n,
   input logic [ONCHIP_W-1:0]  chip_addr,
   input logic                 ram_we_n
);
   logic [RAM_COUNT:0] all_sel;
   assign all_sel = {~rom_cs_n, ~ram_cs_n};

   always_comb begin
      if (!$isunknown({cpu_addr, mreq_n, rd_wr_n})) begin
         // R1: idle strobe keeps everything high
         p_idle_quiet_r1: assert (!mreq_n || (rom_cs_n && &ram_cs_n && ram_we_n));
         // R5: never two selects at once
         p_one_select_r5: assert ($countones(all_sel) <= 1);
         // R6: on-chip address passthrough
         p_chip_addr_r6: assert (chip_addr == cpu_addr[ONCHIP_W-1:0]);
         // R7: a write strobe only reaches a selected RAM group
         p_we_needs_ram_r7: assert (ram_we_n || (!mreq_n && !rd_wr_n && !(&ram_cs_n)));
         // R8: reads never write
         p_read_no_we_r8: assert (!rd_wr_n || ram_we_n);
         // R3: hole addresses select nothing
         p_hole_quiet_r3: assert (mreq_n || cpu_addr[ADDR_W-1:ONCHIP_W] != 3'b010
                                  || (rom_cs_n && &ram_cs_n));
      end
   end
endmodule

bind cs_decoder cs_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .ONCHIP_W  (ONCHIP_W),
   .RAM_COUNT (RAM_COUNT)
) chk_i (
   .cpu_addr  (cpu_addr),
   .mreq_n    (mreq_n),
   .rd_wr_n   (rd_wr_n),
   .rom_cs_n  (rom_cs_n),
   .ram_cs_n  (ram_cs_n),
   .chip_addr (chip_addr),
   .ram_we_n  (ram_we_n)
);

// File: tb/cs_decoder_tb_top.sv
module cs_decoder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        mreq_n = 1'b1;
   logic        rd_wr_n = 1'b1;
   logic        rom_cs_n;
   logic [4:0]  ram_cs_n;
   logic [12:0] chip_addr;
   logic        ram_we_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_decoder dut_i (
      .cpu_addr  (cpu_addr),
      .mreq_n    (mreq_n),
      .rd_wr_n   (rd_wr_n),
      .rom_cs_n  (rom_cs_n),
      .ram_cs_n  (ram_cs_n),
      .chip_addr (chip_addr),
      .ram_we_n  (ram_we_n)
   );

   // Expected ROM select from the memory map
   function automatic logic exp_rom(logic [15:0] a, logic mq);
      return !(mq == 1'b0 && a[15:13] <= 3'd1);
   endfunction

   function automatic logic [4:0] exp_ram(logic [15:0] a, logic mq);
      logic [4:0] r = 5'h1F;
      if (mq == 1'b0 && a[15:13] >= 3'd3) r[a[15:13] - 3'd3] = 1'b0;
      return r;
   endfunction

   function automatic logic exp_we(logic [15:0] a, logic mq, logic rw);
      return !(mq == 1'b0 && rw == 1'b0 && a[15:13] >= 3'd3);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr=%h mreq_n=%b rd_wr_n=%b actual=%h expected=%h",
                  tag, cpu_addr, mreq_n, rd_wr_n, act, exp);
      end
   endtask

   task automatic apply(logic [15:0] a, logic mq, logic rw);
      @(posedge clk);
      cpu_addr = a; mreq_n = mq; rd_wr_n = rw;
      @(negedge clk);
      begin
         string tag;
         if (mq) tag = "R1";
         else if (a[15:13] <= 3'd1) tag = "R2";
         else if (a[15:13] == 3'd2) tag = "R3";
         else tag = "R4";
         check(tag, {26'd0, rom_cs_n, ram_cs_n}, {26'd0, exp_rom(a, mq), exp_ram(a, mq)});
      end
      check("R5", $countones({~rom_cs_n, ~ram_cs_n}) <= 1, 1);
      check("R6", {19'd0, chip_addr}, {19'd0, a[12:0]});
      check(rw ? "R8" : "R7", {31'd0, ram_we_n}, {31'd0, exp_we(a, mq, rw)});
   endtask

   initial begin
      void'($urandom(32'h5EED_0C5D));
      repeat (2) @(posedge clk);
      // Reset/idle state: strobe inactive
      @(negedge clk);
      check("R1", {26'd0, rom_cs_n, ram_cs_n}, 32'h3F);
      check("R1", {31'd0, ram_we_n}, 32'd1);
      // Directed sweep of every bank, strobe and direction
      for (int b = 0; b < 8; b++) begin
         for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
               apply({b[2:0], 13'h0000}, m[0], w[0]);
               apply({b[2:0], 13'h1FFF}, m[0], w[0]);
               apply({b[2:0], 13'(($urandom))}, m[0], w[0]);
            end
         end
      end
      // Region edges
      apply(16'h3FFF, 1'b0, 1'b0);  // last ROM word, write ignored
      apply(16'h4000, 1'b0, 1'b1);  // first hole word
      apply(16'h5FFF, 1'b0, 1'b0);  // last hole word, write
      apply(16'h6000, 1'b0, 1'b0);  // first RAM word
      apply(16'hFFFF, 1'b0, 1'b0);  // last RAM word
      // Random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         apply(r[15:0], r[16] & r[17], r[18]);
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule